// File: doc/BRIEF.md
# Two-Client Request/Grant/Done Arbiter

This block gives two clients mutually exclusive use of one shared resource. Each client has three handshake wires: a request and a done that come into the block, and a grant that goes out. Every event on these wires is a change of level, in either direction. A client asks for the resource with a request event. The block answers with a grant event, and the client gives the resource back with a done event. After a grant, the client's done and its next request may arrive in either order or in the same cycle.

When both clients are waiting and the resource is free, the block grants exactly one of them. It takes turns, so contention that never ends still serves both clients. Any event outside the protocol is fatal. Such an event is a done from a client that does not hold the resource, or a second request while the previous request has not yet been released. A fatal event sets a sticky error output and freezes both grant outputs. Only a synchronous reset clears it.

Top module: `arb2_rgd_arbiter`

## Requirements
- R1: After a synchronous reset, both grant outputs are low, the error output is low, no request is pending and the resource is free.
- R2: An event is any change of level on an input, sampled at a rising clock edge. A request event sampled at edge k, with the resource free and no other client waiting, toggles that client's grant output (bit 0 for client 0, bit 1 for client 1) at edge k+1.
- R3: At most one client holds the resource at a time. A grant is only issued while no client holds it. A waiting client is granted at the earliest one edge after the edge that samples the releasing done.
- R4: A grant edge toggles at most one grant output. A waiting client stays ungranted for as long as the other client holds the resource.
- R5: When both clients are waiting on a free resource, the client that was not granted last wins. After reset, client 0 wins.
- R6: After its grant, a client may send its done and its next request in either order, or both at the same edge, without raising the error.
- R7: A done event from a client that does not hold the resource sets the error. This includes a done before any grant and a done while the other client holds the resource.
- R8: A request event from a client whose earlier request has not yet been granted sets the error.
- R9: The error output stays high until reset. While it is high, and at the edge that detects the violation, no grant output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 2 | Request wires, one per client, transition signalled |
| done_i | input | 2 | Done wires, one per client, transition signalled |
| grant_o | output | 2 | Grant wires, one per client, toggled once per grant |
| proto_err_o | output | 1 | Sticky handshake-violation flag |

## Verification
The assertions check on every cycle that no two clients own the resource and that each grant edge toggles one output at most. They also check that a grant goes only to a waiting client while the resource is free, and that under contention the favoured client wins. Once set, the error flag stays high and the grants stay frozen, which is also checked every cycle. Other behaviour can only be shown by the bench's scenarios. These are the one-edge latency from request or done to grant, the acceptance of done and the next request in either order or together, and the detection of each kind of violation. The bench covers them with a reference model that it compares against the outputs on every cycle.

// File: rtl/arb2_pkg.sv
package arb2_pkg;

    localparam int unsigned NUM_CLIENTS = 2;
    localparam int unsigned CID_W       = $clog2(NUM_CLIENTS);

    typedef logic [CID_W-1:0] cid_t;

    // Per-client handshake progress
    typedef struct packed {
        logic waiting;   // request seen, not yet granted
        logic owns;      // granted, done not yet seen
    } client_st_t;

    // Events sampled this cycle for one client
    typedef struct packed {
        logic req;
        logic done;
    } client_ev_t;

    // Arbitration decision
    typedef struct packed {
        logic fire;
        cid_t who;
    } grant_dec_t;

    function automatic cid_t other_client(input cid_t c);
        return cid_t'(~c);
    endfunction

    function automatic logic breaks_protocol(input client_st_t s, input client_ev_t e);
        return (e.req & s.waiting) | (e.done & ~s.owns);
    endfunction

endpackage

// File: rtl/arb2_toggle_detect.sv
module arb2_toggle_detect #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] event_o
);

    logic [WIDTH-1:0] level_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            level_q <= '0;
        end else begin
            level_q <= level_i;
        end
    end

    // A change against the last sampled level is one event
    assign event_o = level_i ^ level_q;

endmodule

// File: rtl/arb2_client_track.sv
module arb2_client_track
    import arb2_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  client_ev_t ev_i,
    input  logic       take_i,
    input  logic       freeze_i,
    output client_st_t st_o,
    output logic       viol_o
);

    client_st_t st_q, st_d;

    always_comb begin
        viol_o = breaks_protocol(st_q, ev_i);
        st_d   = st_q;
        if (take_i) begin
            st_d.waiting = 1'b0;
            st_d.owns    = 1'b1;
        end else begin
            if (ev_i.done) st_d.owns    = 1'b0;
            if (ev_i.req)  st_d.waiting = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else if (!freeze_i) begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/arb2_grant_pick.sv
module arb2_grant_pick
    import arb2_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [NUM_CLIENTS-1:0] waiting_i,
    input  logic [NUM_CLIENTS-1:0] owns_i,
    input  logic                   enable_i,
    output grant_dec_t             dec_o,
    output cid_t                   favour_o
);

    cid_t favour_q;

    always_comb begin
        dec_o.fire = enable_i & ~(|owns_i) & (|waiting_i);
        if (&waiting_i) begin
            dec_o.who = favour_q;
        end else begin
            dec_o.who = waiting_i[1] ? cid_t'(1) : cid_t'(0);
        end
    end

    // Round-robin pointer: the loser of the last grant is favoured next
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            favour_q <= cid_t'(0);
        end else if (dec_o.fire) begin
            favour_q <= other_client(dec_o.who);
        end
    end

    assign favour_o = favour_q;

endmodule

// File: rtl/arb2_rgd_arbiter.sv
module arb2_rgd_arbiter
    import arb2_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [NUM_CLIENTS-1:0] req_i,
    input  logic [NUM_CLIENTS-1:0] done_i,
    output logic [NUM_CLIENTS-1:0] grant_o,
    output logic                   proto_err_o
);

    logic [NUM_CLIENTS-1:0] req_ev, done_ev;
    logic [NUM_CLIENTS-1:0] waiting_v, owns_v, viol_v, take_v;
    logic                   err_q, freeze;
    logic [NUM_CLIENTS-1:0] gnt_q;
    grant_dec_t             dec;
    cid_t                   favour;

    arb2_toggle_detect #(.WIDTH(NUM_CLIENTS)) req_det_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (req_i),
        .event_o (req_ev)
    );

    arb2_toggle_detect #(.WIDTH(NUM_CLIENTS)) done_det_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (done_i),
        .event_o (done_ev)
    );

    assign freeze = err_q | (|viol_v);

    for (genvar i = 0; i < NUM_CLIENTS; i++) begin : g_client
        client_ev_t cev;
        client_st_t cst;

        assign cev.req   = req_ev[i];
        assign cev.done  = done_ev[i];
        assign take_v[i] = dec.fire && (dec.who == cid_t'(i));

        arb2_client_track track_i (
            .clk_i    (clk_i),
            .rst_i    (rst_i),
            .ev_i     (cev),
            .take_i   (take_v[i]),
            .freeze_i (freeze),
            .st_o     (cst),
            .viol_o   (viol_v[i])
        );

        assign waiting_v[i] = cst.waiting;
        assign owns_v[i]    = cst.owns;

        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                gnt_q[i] <= 1'b0;
            end else if (take_v[i]) begin
                gnt_q[i] <= ~gnt_q[i];
            end
        end
    end

    arb2_grant_pick pick_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .waiting_i (waiting_v),
        .owns_i    (owns_v),
        .enable_i  (~freeze),
        .dec_o     (dec),
        .favour_o  (favour)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            err_q <= 1'b0;
        end else if (|viol_v) begin
            err_q <= 1'b1;
        end
    end

    assign grant_o     = gnt_q;
    assign proto_err_o = err_q;

endmodule

// File: rtl/arb2_rgd_checker.sv
module arb2_rgd_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic [1:0] grant_o,
    input logic       proto_err_o,
    input logic [1:0] waiting_v,
    input logic [1:0] owns_v,
    input logic [0:0] favour
);

    assert_one_owner_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !(owns_v[0] && owns_v[1]));

    assert_single_toggle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(grant_o ^ $past(grant_o)) <= 1);

    assert_grant_when_free_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant_o != $past(grant_o)) |-> ($past(owns_v) == 2'b00));

    assert_grant0_to_waiter_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant_o[0] != $past(grant_o[0])) |-> $past(waiting_v[0]));

    assert_grant1_to_waiter_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (grant_o[1] != $past(grant_o[1])) |-> $past(waiting_v[1]));

    assert_fair_pick_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        ((grant_o != $past(grant_o)) && ($past(waiting_v) == 2'b11))
        |-> ((grant_o ^ $past(grant_o)) == (2'b01 << $past(favour))));

    assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        proto_err_o |=> proto_err_o);

    assert_err_freeze_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        proto_err_o |=> $stable(grant_o));

endmodule

bind arb2_rgd_arbiter arb2_rgd_checker chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .grant_o     (grant_o),
    .proto_err_o (proto_err_o),
    .waiting_v   (waiting_v),
    .owns_v      (owns_v),
    .favour      (favour)
);

// File: tb/arb2_rgd_arbiter_tb.sv
module arb2_rgd_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] req_lvl = 2'b00;
    logic [1:0] done_lvl = 2'b00;
    logic [1:0] grant_o;
    logic       proto_err_o;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;

    // Reference model state
    logic [1:0] m_pend, m_hold, m_gnt;
    logic       m_prio, m_err;

    always #2 clk = ~clk;

    arb2_rgd_arbiter dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .req_i       (req_lvl),
        .done_i      (done_lvl),
        .grant_o     (grant_o),
        .proto_err_o (proto_err_o)
    );

    task automatic peek(input string tag, input logic [1:0] exp_g, input logic exp_e);
        n_checks++;
        if (grant_o !== exp_g || proto_err_o !== exp_e) begin
            n_fail++;
            $display("FAIL %s: grant=%b err=%b expected grant=%b err=%b",
                     tag, grant_o, proto_err_o, exp_g, exp_e);
        end
    endtask

    task automatic model_step(input logic [1:0] er, input logic [1:0] ed);
        logic       viol;
        logic [1:0] gm;
        viol = (|(er & m_pend)) || (|(ed & ~m_hold));
        if (m_err) return;
        if (viol) begin
            m_err = 1'b1;
            return;
        end
        gm = 2'b00;
        if (m_hold == 2'b00 && m_pend != 2'b00) begin
            if (m_pend == 2'b11) gm = m_prio ? 2'b10 : 2'b01;
            else                 gm = m_pend;
            m_prio = gm[0];
        end
        m_gnt  = m_gnt ^ gm;
        m_hold = (m_hold & ~ed) | gm;
        m_pend = (m_pend | er) & ~gm;
    endtask

    // Check outputs against the model, then drive events for the next edge
    task automatic step(input logic [1:0] er, input logic [1:0] ed, input string tag);
        @(negedge clk);
        peek(tag, m_gnt, m_err);
        req_lvl  = req_lvl ^ er;
        done_lvl = done_lvl ^ ed;
        model_step(er, ed);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_lvl = 2'b00;
        done_lvl = 2'b00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pend = 2'b00; m_hold = 2'b00; m_gnt = 2'b00;
        m_prio = 1'b0;  m_err = 1'b0;
        peek("R1 reset state", 2'b00, 1'b0);
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) step(2'b00, 2'b00, tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [1:0] er, ed;
        void'($urandom(32'd20240611));

        // R1
        do_reset();

        // R2: single request granted one edge after it is sampled
        step(2'b01, 2'b00, "R2");
        step(2'b00, 2'b00, "R2");
        peek("R2 not yet granted", 2'b00, 1'b0);
        step(2'b00, 2'b00, "R2");
        peek("R2 grant client 0", 2'b01, 1'b0);
        step(2'b00, 2'b01, "R3");
        idle(2, "R3");

        // R5/R4/R3: contention from reset favours client 0
        do_reset();
        step(2'b11, 2'b00, "R5");
        step(2'b00, 2'b00, "R5");
        step(2'b00, 2'b00, "R5");
        peek("R5 client 0 wins after reset", 2'b01, 1'b0);
        idle(4, "R4");
        peek("R4 client 1 held back", 2'b01, 1'b0);
        step(2'b00, 2'b01, "R3");
        step(2'b00, 2'b00, "R3");
        peek("R3 no grant on release edge", 2'b01, 1'b0);
        step(2'b00, 2'b00, "R3");
        peek("R3 client 1 granted after release", 2'b11, 1'b0);

        // R6: client 0 requests early, client 1 done+request together
        step(2'b01, 2'b00, "R6");
        step(2'b10, 2'b10, "R6");
        idle(2, "R6");
        peek("R6 client 0 granted, no error", 2'b10, 1'b0);
        // R5: client 1 was not granted last, so it wins next
        step(2'b00, 2'b01, "R5");
        idle(2, "R5");
        peek("R5 client 1 granted by rotation", 2'b00, 1'b0);
        // R6: request before done on client 1
        step(2'b10, 2'b00, "R6");
        step(2'b00, 2'b10, "R6");
        idle(3, "R6");
        peek("R6 request-then-done accepted", 2'b10, 1'b0);

        // R7: done before any grant
        do_reset();
        step(2'b00, 2'b01, "R7");
        step(2'b00, 2'b00, "R7");
        peek("R7 early done flags error", 2'b00, 1'b1);
        // R9: frozen and sticky
        step(2'b01, 2'b00, "R9");
        idle(4, "R9");
        peek("R9 error holds, grant frozen", 2'b00, 1'b1);
        do_reset();

        // R7: done from client 1 while client 0 holds
        step(2'b01, 2'b00, "R7");
        idle(2, "R7");
        step(2'b00, 2'b10, "R7");
        step(2'b00, 2'b00, "R7");
        peek("R7 foreign done flags error", 2'b01, 1'b1);

        // R8: second request while still waiting, no grant at that edge
        do_reset();
        step(2'b01, 2'b00, "R8");
        step(2'b01, 2'b00, "R8");
        step(2'b00, 2'b00, "R8");
        peek("R8 double request flags error", 2'b00, 1'b1);

        // Random legal traffic
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < 2; i++) begin
                er[i] = !m_pend[i] && ($urandom_range(0, 2) == 0);
                ed[i] = m_hold[i]  && ($urandom_range(0, 2) == 0);
            end
            step(er, ed, "R6 random legal");
        end

        // Random traffic with occasional violations
        for (int c = 0; c < 3000; c++) begin
            if (m_err && $urandom_range(0, 7) == 0) do_reset();
            for (int i = 0; i < 2; i++) begin
                er[i] = ($urandom_range(0, 59) == 0) ? 1'b1
                      : (!m_pend[i] && ($urandom_range(0, 2) == 0));
                ed[i] = ($urandom_range(0, 59) == 0) ? 1'b1
                      : (m_hold[i] && ($urandom_range(0, 2) == 0));
            end
            step(er, ed, "R9 random mixed");
        end
        step(2'b00, 2'b00, "R9");

        finish_run();
    end

endmodule